// File: doc/BRIEF.md
# Subtrie Longest-Prefix Matcher

This block finds the longest matching prefix inside one binary subtrie of depth K (K = 7 by default, so the subtrie has 255 nodes). Each subtrie is held as a presence bitmap called the tree vector. Bit position `NODES-1-i` is set when node i carries a prefix, so node 0 sits in the leftmost (most significant) position. The K address bits pick one root-to-leaf path. That path becomes a path mask of the same width.

A lookup runs through three registered stages:
- The tree vector for the chosen subtree is read and the path mask is formed.
- The two vectors are ANDed, and a rightmost-one locator picks the deepest surviving node.
- The next hop for that node is read from a routing array indexed by (subtree, node).

A new lookup can enter every cycle. Software-side writes load whole tree vectors and single next-hop entries. Splitting a full table into subtries is done elsewhere.

Top module: `tvm_top`

## Requirements
- R1: While reset is high, and on the first edge after it falls, `res_valid`, `res_found`, `res_node` and `res_hop` are all 0.
- R2: A lookup presented with `lk_valid` high at a rising edge yields `res_valid` high after the third rising edge, counting that edge as the first. Lookups on consecutive cycles give results on consecutive cycles, in order.
- R3: Nodes are numbered breadth-first with the root as node 0. From node n, an address bit of 0 leads to node 2n+1 and a bit of 1 leads to node 2n+2. Address bits are consumed most significant first. Node i is present when `tv_data[NODES-1-i]` was written as 1.
- R4: When any node on the selected path is present, `res_found` is 1 and `res_node` is the deepest present node on that path.
- R5: When no node on the path is present, `res_found` is 0 and both `res_node` and `res_hop` are 0, even if next-hop entries exist for that subtree.
- R6: On a match, `res_hop` equals the value last written to the routing entry for (lookup subtree, matched node).
- R7: Each subtree has its own tree vector and routing entries. A lookup uses only those of `lk_sub`.
- R8: A tree-vector write replaces the whole bitmap of that subtree. Lookups presented in later cycles see only the new bitmap.
- R9: With `lk_valid` low, the matching result slot has `res_valid` and `res_found` both 0.
- R10: Present nodes that are off the selected path have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_sub | input | SUB_W (2) | Subtree to search |
| lk_addr | input | ADDR_BITS (7) | Path-selecting address bits, MSB consumed first |
| tv_we | input | 1 | Tree-vector write enable |
| tv_sub | input | SUB_W (2) | Subtree whose bitmap is written |
| tv_data | input | NODES (255) | New bitmap; node i at bit NODES-1-i |
| nh_we | input | 1 | Routing-entry write enable |
| nh_sub | input | SUB_W (2) | Subtree of the routing entry |
| nh_node | input | NODE_W (8) | Node of the routing entry |
| nh_data | input | HOP_W (8) | Next-hop identifier written |
| res_valid | output | 1 | Result slot holds a lookup |
| res_found | output | 1 | A prefix matched |
| res_node | output | NODE_W (8) | Matched node, 0 on a miss |
| res_hop | output | HOP_W (8) | Next hop, 0 on a miss |

## Verification
Each result appears after three rising edges, one per pipeline register. The bench drives a lookup on a falling edge and reads the result on the third falling edge after that, which is half a cycle after the third rising edge. In the back-to-back walk over the vector table, every falling edge first checks the entry driven three falling edges earlier and then drives the next one, so each check lines up with its own lookup while the pipe is full. Idle slots, bitmap rewrites and reset are checked with the same three-edge offset.

// File: rtl/tvm_pkg.sv
package tvm_pkg;
    localparam int ADDR_BITS = 7;
    localparam int SUBTREES  = 4;
    localparam int HOP_W     = 8;
    localparam int NODES     = (1 << (ADDR_BITS + 1)) - 1;
    localparam int NODE_W    = $clog2(NODES);
    localparam int SUB_W     = $clog2(SUBTREES);

    typedef logic [NODES-1:0]     tvec_t;
    typedef logic [NODE_W-1:0]    node_t;
    typedef logic [SUB_W-1:0]     sub_t;
    typedef logic [ADDR_BITS-1:0] addr_t;
    typedef logic [HOP_W-1:0]     hop_t;

    typedef struct packed {
        logic  vld;
        sub_t  sub;
        tvec_t tree;
        tvec_t mask;
    } s1_t;

    typedef struct packed {
        logic  vld;
        sub_t  sub;
        logic  hit;
        node_t node;
    } s2_t;

    // Bit position that holds node n (node 0 is leftmost).
    function automatic int node_pos(input int n);
        return NODES - 1 - n;
    endfunction

    // Path mask: root plus one node per address bit, MSB first.
    function automatic tvec_t path_mask(input addr_t a);
        tvec_t m;
        int    n;
        m = '0;
        n = 0;
        m[node_pos(0)] = 1'b1;
        for (int d = 0; d < ADDR_BITS; d++) begin
            n = 2 * n + 1 + int'(a[ADDR_BITS-1-d]);
            m[node_pos(n)] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/tvm_tree_stage.sv
module tvm_tree_stage
    import tvm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lk_valid,
    input  sub_t  lk_sub,
    input  addr_t lk_addr,
    input  logic  tv_we,
    input  sub_t  tv_sub,
    input  tvec_t tv_data,
    output s1_t   s1
);
    tvec_t tree_mem [SUBTREES];

    always_ff @(posedge clk) begin
        if (tv_we) tree_mem[tv_sub] <= tv_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld  <= lk_valid;
            s1.sub  <= lk_sub;
            s1.tree <= tree_mem[lk_sub];
            s1.mask <= path_mask(lk_addr);
        end
    end
endmodule

// File: rtl/tvm_rmo_locate.sv
module tvm_rmo_locate
    import tvm_pkg::*;
(
    input  tvec_t vec,
    output logic  hit,
    output node_t node
);
    // Highest bit first; the lowest set position is written last and wins.
    always_comb begin
        hit  = 1'b0;
        node = '0;
        for (int p = NODES - 1; p >= 0; p--) begin
            if (vec[p]) begin
                hit  = 1'b1;
                node = node_t'(NODES - 1 - p);
            end
        end
    end
endmodule

// File: rtl/tvm_hop_stage.sv
module tvm_hop_stage
    import tvm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  s2_t   s2,
    input  logic  nh_we,
    input  sub_t  nh_sub,
    input  node_t nh_node,
    input  hop_t  nh_data,
    output logic  res_valid,
    output logic  res_found,
    output node_t res_node,
    output hop_t  res_hop
);
    hop_t hop_mem [SUBTREES][NODES];

    always_ff @(posedge clk) begin
        if (nh_we) hop_mem[nh_sub][nh_node] <= nh_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_found <= 1'b0;
            res_node  <= '0;
            res_hop   <= '0;
        end else begin
            res_valid <= s2.vld;
            res_found <= s2.vld && s2.hit;
            res_node  <= (s2.vld && s2.hit) ? s2.node : '0;
            res_hop   <= (s2.vld && s2.hit) ? hop_mem[s2.sub][s2.node] : '0;
        end
    end
endmodule

// File: rtl/tvm_top.sv
module tvm_top
    import tvm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    input  logic [SUB_W-1:0]     lk_sub,
    input  logic [ADDR_BITS-1:0] lk_addr,
    input  logic                 tv_we,
    input  logic [SUB_W-1:0]     tv_sub,
    input  logic [NODES-1:0]     tv_data,
    input  logic                 nh_we,
    input  logic [SUB_W-1:0]     nh_sub,
    input  logic [NODE_W-1:0]    nh_node,
    input  logic [HOP_W-1:0]     nh_data,
    output logic                 res_valid,
    output logic                 res_found,
    output logic [NODE_W-1:0]    res_node,
    output logic [HOP_W-1:0]     res_hop
);
    s1_t   s1;
    s2_t   s2;
    tvec_t and_vec;
    logic  hit_c;
    node_t node_c;

    tvm_tree_stage u_tree (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_sub(lk_sub),
        .lk_addr(lk_addr), .tv_we(tv_we), .tv_sub(tv_sub),
        .tv_data(tv_data), .s1(s1)
    );

    assign and_vec = s1.tree & s1.mask;

    tvm_rmo_locate u_loc (.vec(and_vec), .hit(hit_c), .node(node_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.vld  <= s1.vld;
            s2.sub  <= s1.sub;
            s2.hit  <= s1.vld && hit_c;
            s2.node <= node_c;
        end
    end

    tvm_hop_stage u_hop (
        .clk(clk), .rst(rst), .s2(s2), .nh_we(nh_we), .nh_sub(nh_sub),
        .nh_node(nh_node), .nh_data(nh_data), .res_valid(res_valid),
        .res_found(res_found), .res_node(res_node), .res_hop(res_hop)
    );

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && !res_found && res_hop == '0));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(lk_valid, 3));

    assert_pick_present_R4: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && hit_c) |-> and_vec[NODES - 1 - int'(node_c)]);

    assert_miss_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && !hit_c) |-> (and_vec == '0));

    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_found) |-> (res_hop == '0 && res_node == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_found);
endmodule

// File: tb/tb_tvm_top.sv
`timescale 1ns/1ps
module tb_tvm_top;
    import tvm_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic lk_valid;
    sub_t lk_sub;
    addr_t lk_addr;
    logic tv_we;
    sub_t tv_sub;
    tvec_t tv_data;
    logic nh_we;
    sub_t nh_sub;
    node_t nh_node;
    hop_t nh_data;
    logic res_valid, res_found;
    node_t res_node;
    hop_t res_hop;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tvm_top dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_sub(lk_sub),
        .lk_addr(lk_addr), .tv_we(tv_we), .tv_sub(tv_sub), .tv_data(tv_data),
        .nh_we(nh_we), .nh_sub(nh_sub), .nh_node(nh_node), .nh_data(nh_data),
        .res_valid(res_valid), .res_found(res_found), .res_node(res_node),
        .res_hop(res_hop)
    );

    typedef struct packed {
        logic [1:0] sub;
        logic [6:0] addr;
        logic       found;
        logic [7:0] node;
    } vec_t;

    // Sub0 holds {0,2,3,5,6,254}; sub1 holds {1,127}; sub2 is empty.
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 7'h00, 1'b1, 8'd3},
        '{2'd0, 7'h7F, 1'b1, 8'd254},
        '{2'd0, 7'h40, 1'b1, 8'd5},
        '{2'd0, 7'h60, 1'b1, 8'd6},
        '{2'd0, 7'h20, 1'b1, 8'd0},
        '{2'd1, 7'h00, 1'b1, 8'd127},
        '{2'd1, 7'h01, 1'b1, 8'd1},
        '{2'd1, 7'h40, 1'b0, 8'd0},
        '{2'd2, 7'h00, 1'b0, 8'd0}
    };

    function automatic hop_t hopval(input int s, input int n);
        return hop_t'((s * 37 + n * 3 + 1) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_tree(input int s, input tvec_t v);
        @(negedge clk);
        tv_we = 1'b1; tv_sub = sub_t'(s); tv_data = v;
        @(negedge clk);
        tv_we = 1'b0;
    endtask

    task automatic wr_hop(input int s, input int n);
        @(negedge clk);
        nh_we = 1'b1; nh_sub = sub_t'(s); nh_node = node_t'(n); nh_data = hopval(s, n);
        @(negedge clk);
        nh_we = 1'b0;
    endtask

    // Drive on a falling edge, sample on the third falling edge after.
    task automatic lookup(input int s, input int a);
        @(negedge clk);
        lk_valid = 1'b1; lk_sub = sub_t'(s); lk_addr = addr_t'(a);
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic tvec_t mk(input int a, input int b, input int c,
                                 input int d, input int e, input int f);
        tvec_t v;
        v = '0;
        if (a >= 0) v[NODES-1-a] = 1'b1;
        if (b >= 0) v[NODES-1-b] = 1'b1;
        if (c >= 0) v[NODES-1-c] = 1'b1;
        if (d >= 0) v[NODES-1-d] = 1'b1;
        if (e >= 0) v[NODES-1-e] = 1'b1;
        if (f >= 0) v[NODES-1-f] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lk_valid = 0; lk_sub = '0; lk_addr = '0;
        tv_we = 0; tv_sub = '0; tv_data = '0;
        nh_we = 0; nh_sub = '0; nh_node = '0; nh_data = '0;
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset
        chk("R1 valid in reset", int'(res_valid), 0);
        chk("R1 found in reset", int'(res_found), 0);
        chk("R1 hop in reset", int'(res_hop), 0);
        rst = 1'b0;

        wr_tree(0, mk(0, 2, 3, 5, 6, 254));
        wr_tree(1, mk(1, 127, -1, -1, -1, -1));
        wr_tree(2, '0);
        wr_hop(0, 0); wr_hop(0, 3); wr_hop(0, 5); wr_hop(0, 6); wr_hop(0, 254);
        wr_hop(1, 0); wr_hop(1, 1); wr_hop(1, 127); wr_hop(2, 0);

        // Table walk, back to back (R2, R3, R4, R5, R6, R7, R10)
        for (int c = 0; c < NV + 3; c++) begin
            @(negedge clk);
            if (c >= 3) begin
                vec_t e;
                e = VECS[c-3];
                chk("R2 valid in slot", int'(res_valid), 1);
                chk("R4 found", int'(res_found), int'(e.found));
                chk("R3 node", int'(res_node), int'(e.node));
                if (e.found)
                    chk("R6 hop", int'(res_hop), int'(hopval(int'(e.sub), int'(e.node))));
                else
                    chk("R5 hop on miss", int'(res_hop), 0);
            end
            if (c < NV) begin
                lk_valid = 1'b1; lk_sub = VECS[c].sub; lk_addr = VECS[c].addr;
            end else begin
                lk_valid = 1'b0;
            end
        end
        // R9: idle slots after the burst
        @(negedge clk);
        chk("R9 idle valid", int'(res_valid), 0);
        chk("R9 idle found", int'(res_found), 0);

        // R8: rewrite sub2 with root only
        wr_tree(2, mk(0, -1, -1, -1, -1, -1));
        lookup(2, 7'h15);
        chk("R8 found after write", int'(res_found), 1);
        chk("R8 node after write", int'(res_node), 0);
        chk("R8 hop after write", int'(res_hop), int'(hopval(2, 0)));

        // R8: full replacement of sub0 with only node 254
        wr_tree(0, mk(254, -1, -1, -1, -1, -1));
        lookup(0, 7'h00);
        chk("R8 old nodes gone", int'(res_found), 0);
        lookup(0, 7'h7F);
        chk("R8 kept leaf", int'(res_node), 254);

        // R7: sub1 untouched by sub0 rewrite
        lookup(1, 7'h00);
        chk("R7 other subtree node", int'(res_node), 127);
        chk("R7 other subtree hop", int'(res_hop), int'(hopval(1, 127)));

        // R1: reset during traffic clears result
        @(negedge clk);
        lk_valid = 1'b1; lk_sub = 2'd1; lk_addr = 7'h00;
        @(negedge clk);
        lk_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 valid after reset", int'(res_valid), 0);
        @(negedge clk);
        chk("R1 found after reset", int'(res_found), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule